// File: doc/BRIEF.md
# Vectored Nesting Interrupt Controller

The block collects 32 level-sensitive interrupt sources and drives two processor request lines: a normal request (`irq_o`) and a fast request (`fiq_o`). Each source is active when its hardware input is high or software has set its bit. A per-source select register steers a source to the fast line. Sources that are not steered there, and that are enabled, feed the normal line.

Sixteen vector slots each bind one source to a 32-bit handler address. A lower slot index means a higher priority. A default address serves every source that has no enabled slot, and these sources share one unvectored level below all the slots. The block keeps the priority level of the handler being serviced. While a handler runs, only sources bound to a more urgent slot can raise `irq_o`.

Software enters a handler by reading the vector register. This read returns the handler address of the best pending level and raises the current level to it. Software leaves the handler by writing the vector register, which drops back to the level that was active before entry. Register access uses a simple synchronous bus. It never stalls, read data is valid in the same cycle, and a write takes effect at the clock edge.

Top module: `vic_ctrl`

## Requirements
- R1: Word 0x008 reads the raw source vector: hardware line OR software bit, per source. Word 0x000 reads the normal status: raw AND enable AND NOT fast-select. Word 0x004 reads the fast status: raw AND fast-select.
- R2: A write of ones to 0x010 sets enable bits and a write of ones to 0x014 clears them. Reading 0x010 returns the enables. Software bits work the same way: 0x018 sets them, 0x01C clears them, and reading 0x018 returns them.
- R3: Word 0x00C holds the fast-select bits. `fiq_o` is high whenever a raw source that is fast-selected is active, whatever its enable bit. Fast-selected sources never appear in the normal status.
- R4: When the current level is idle, `irq_o` is high exactly when the normal status is nonzero.
- R5: A slot control byte at 0x200+4*n uses bit 5 as slot enable and bits 4:0 as the source number. Its handler address lives at 0x100+4*n. A slot whose bit 5 is clear does not vector its source. When two slots are pending, the lower index wins.
- R6: Reading 0x030 picks the most urgent level below the current one that has a raw source pending. It saves the current level for that level, enters it, and returns that slot's address. The unvectored level returns the default address held at 0x034.
- R7: Reading 0x030 with no eligible pending level returns the default address and leaves the current level unchanged.
- R8: Any write to 0x030 restores the level saved on entry to the current level, and the written data is ignored. When the current level is idle, such a write has no effect.
- R9: While a handler runs at level L, `irq_o` is raised only by enabled normal sources bound to enabled slots below L. At the unvectored level, every vectored source counts as below L.
- R10: Writes to the normal status word have no effect. Unmapped words read as zero and writes to them change nothing.
- R11: Words 0xFE0 to 0xFFC read eight fixed identification bytes, the first being 0x52 and the last 0xB1. Bit 0 of word 0x020 is stored and read back.
- R12: Reset clears the enables, software bits, fast-select bits, slot controls, slot addresses and default address, and sets the current level to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Level-sensitive hardware interrupt lines |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Three slots of falling urgency are armed. Their sources are raised in rising-urgency order, so each vector read nests one level deeper, and each exit write must unwind to the exact level before it. This sequence separates a correct save per level from a design that only returns to idle. An unvectored source raised during a handler, and a vectored source raised during the unvectored handler, show whether the blocking mask is taken at the current level. Two pending slots raised together, and a slot with its enable bit cleared, test the order and the slot-enable decoding. Steering one source to the fast line with its enable cleared tests that the fast route ignores the enable and never touches the normal status.

// File: rtl/vic_pkg.sv
// Package: shared word indices (byte address / 4) of the controller's
// register map. Assumes a 4 KiB register window with word-aligned access.
package vic_pkg;
    localparam int W_IRQ_STAT = 0;
    localparam int W_FIQ_STAT = 1;
    localparam int W_RAW      = 2;
    localparam int W_FSEL     = 3;
    localparam int W_EN_SET   = 4;
    localparam int W_EN_CLR   = 5;
    localparam int W_SW_SET   = 6;
    localparam int W_SW_CLR   = 7;
    localparam int W_PROT     = 8;
    localparam int W_VECT     = 12;
    localparam int W_DEF      = 13;
    localparam int W_SLOT_ADR = 64;    // 0x100
    localparam int W_SLOT_CTL = 128;   // 0x200
    localparam int W_IDENT    = 1016;  // 0xFE0
endpackage

// File: rtl/vic_src.sv
// Module: vic_src
// Merges hardware lines with software bits and splits the active sources
// into the normal and fast routes. Purely combinational.
module vic_src #(
    parameter int NSRC = 32
) (
    input  logic [NSRC-1:0] hw_lines,
    input  logic [NSRC-1:0] soft_bits,
    input  logic [NSRC-1:0] en_bits,
    input  logic [NSRC-1:0] fiq_bits,
    output logic [NSRC-1:0] raw,
    output logic [NSRC-1:0] irq_stat,
    output logic [NSRC-1:0] fiq_stat,
    output logic            fiq_req
);
    // raw activity: either the pin or the software bit
    assign raw      = hw_lines | soft_bits;
    // normal route: enabled and not steered to the fast line
    assign irq_stat = raw & en_bits & ~fiq_bits;
    // fast route: steered sources, no enable gating
    assign fiq_stat = raw & fiq_bits;
    assign fiq_req  = |fiq_stat;
endmodule

// File: rtl/vic_prio.sv
// Module: vic_prio
// Builds the cumulative blocking mask for every priority level from the
// slot bindings, and searches for the most urgent pending level below the
// current one. Level NSLOT is the unvectored level; level NSLOT+1 is idle.
// Assumes each slot source number is below NSRC.
module vic_prio #(
    parameter int NSRC  = 32,
    parameter int NSLOT = 16,
    parameter int SW    = $clog2(NSRC),
    parameter int PW    = $clog2(NSLOT + 2)
) (
    input  logic [NSLOT-1:0]    slot_en,
    input  logic [NSLOT*SW-1:0] slot_src,
    input  logic [NSRC-1:0]     raw,
    input  logic [NSRC-1:0]     irq_stat,
    input  logic [PW-1:0]       cur,
    output logic                irq_req,
    output logic                win_found,
    output logic [PW-1:0]       win_lvl
);
    localparam int NLVL = NSLOT + 1;

    logic [NSRC-1:0] mask [NLVL+1];
    logic [NLVL-1:0] hit;
    logic [NSRC-1:0] cur_mask;

    assign mask[0] = '0;

    generate
        for (genvar g = 0; g < NSLOT; g++) begin : g_slot
            logic [NSRC-1:0] bind_bit;
            // one-hot source of this slot when the slot is enabled
            assign bind_bit   = slot_en[g] ? (NSRC'(1) << slot_src[g*SW +: SW]) : '0;
            // levels below g+1 block everything bound up to slot g
            assign mask[g+1]  = mask[g] | bind_bit;
            // slot is pending when its raw source is active
            assign hit[g]     = slot_en[g] & raw[slot_src[g*SW +: SW]];
        end
    endgenerate

    assign mask[NLVL]  = '1;
    assign hit[NSLOT]  = |raw;

    // select the blocking mask of the current level
    always_comb begin
        cur_mask = '0;
        for (int i = 0; i <= NLVL; i++) begin
            if (cur == PW'(i)) cur_mask = mask[i];
        end
    end

    assign irq_req = |(irq_stat & cur_mask);

    // most urgent pending level strictly below the current one
    always_comb begin
        win_found = 1'b0;
        win_lvl   = '0;
        for (int i = NLVL - 1; i >= 0; i--) begin
            if (hit[i] && (PW'(i) < cur)) begin
                win_found = 1'b1;
                win_lvl   = PW'(i);
            end
        end
    end
endmodule

// File: rtl/vic_nest.sv
// Module: vic_nest
// Holds the current service level and one saved return level per level.
// enter and leave are assumed never to be high in the same cycle.
module vic_nest #(
    parameter int NLVL = 17,
    parameter int PW   = $clog2(NLVL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enter,
    input  logic [PW-1:0] enter_lvl,
    input  logic          leave,
    output logic [PW-1:0] cur
);
    localparam logic [PW-1:0] IDLE = PW'(NLVL);

    logic [PW-1:0] save_q [NLVL];

    // current level: raised on entry, restored on exit when not idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= IDLE;
        end else if (enter) begin
            cur <= enter_lvl;
        end else if (leave && (cur != IDLE)) begin
            cur <= save_q[cur];
        end
    end

    // return levels: the entered level remembers where it came from
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NLVL; i++) save_q[i] <= IDLE;
        end else if (enter) begin
            save_q[enter_lvl] <= cur;
        end
    end

    // R6
    enter_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> (cur < $past(cur)));

    // R8
    leave_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (leave && !enter && (cur != IDLE)) |=> (cur > $past(cur)));

    // R8
    idle_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (leave && !enter && (cur == IDLE)) |=> (cur == IDLE));
endmodule

// File: rtl/vic_ctrl.sv
// Module: vic_ctrl (top)
// Register file and bus decode of the vectored nesting controller. Reads
// are combinational and zero-wait; writes and the vector-read side effect
// commit on the clock edge. Assumes NSRC <= DW and NSLOT <= 64.
module vic_ctrl #(
    parameter int          NSRC     = 32,
    parameter int          NSLOT    = 16,
    parameter int          DW       = 32,
    parameter int          AW       = 12,
    parameter logic [63:0] ID_BYTES = 64'hB105_F00D_0002_1C52
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            irq_o,
    output logic            fiq_o
);
    import vic_pkg::*;

    localparam int SW   = $clog2(NSRC);
    localparam int SIW  = $clog2(NSLOT);
    localparam int NLVL = NSLOT + 1;
    localparam int PW   = $clog2(NLVL + 1);
    localparam int WW   = AW - 2;

    localparam logic [WW-1:0] WI_IRQ_STAT = WW'(W_IRQ_STAT);
    localparam logic [WW-1:0] WI_FIQ_STAT = WW'(W_FIQ_STAT);
    localparam logic [WW-1:0] WI_RAW      = WW'(W_RAW);
    localparam logic [WW-1:0] WI_FSEL     = WW'(W_FSEL);
    localparam logic [WW-1:0] WI_EN_SET   = WW'(W_EN_SET);
    localparam logic [WW-1:0] WI_EN_CLR   = WW'(W_EN_CLR);
    localparam logic [WW-1:0] WI_SW_SET   = WW'(W_SW_SET);
    localparam logic [WW-1:0] WI_SW_CLR   = WW'(W_SW_CLR);
    localparam logic [WW-1:0] WI_PROT     = WW'(W_PROT);
    localparam logic [WW-1:0] WI_VECT     = WW'(W_VECT);
    localparam logic [WW-1:0] WI_DEF      = WW'(W_DEF);
    localparam logic [WW-1:0] WI_SLA      = WW'(W_SLOT_ADR);
    localparam logic [WW-1:0] WI_SLC      = WW'(W_SLOT_CTL);
    localparam logic [WW-1:0] WI_ID       = WW'(W_IDENT);
    localparam logic [WW-1:0] NSLOT_W     = WW'(NSLOT);
    localparam logic [WW-1:0] NID_W       = WW'(8);

    // architectural state
    logic [NSRC-1:0] en_q, soft_q, fsel_q;
    logic            prot_q;
    logic [DW-1:0]   def_q;
    logic [DW-1:0]   sl_addr_q [NSLOT];
    logic [SW:0]     sl_ctl_q  [NSLOT];

    // decode
    logic [WW-1:0]  widx, sa_off, sc_off, id_off;
    logic           sa_hit, sc_hit, id_hit, wr_stb, rd_stb;
    logic [SIW-1:0] sa_idx, sc_idx;
    logic [63:0]    id_shift;

    // datapath between submodules
    logic [NSRC-1:0]     raw, irq_stat, fiq_stat;
    logic [NSLOT-1:0]    slot_en;
    logic [NSLOT*SW-1:0] slot_src;
    logic                irq_req, win_found, vec_enter, vec_leave;
    logic [PW-1:0]       win_lvl, cur;
    logic [DW-1:0]       vect_rd;

    assign widx   = bus_addr[AW-1:2];
    assign sa_off = widx - WI_SLA;
    assign sc_off = widx - WI_SLC;
    assign id_off = widx - WI_ID;
    assign sa_hit = sa_off < NSLOT_W;
    assign sc_hit = sc_off < NSLOT_W;
    assign id_hit = id_off < NID_W;
    assign sa_idx = sa_off[SIW-1:0];
    assign sc_idx = sc_off[SIW-1:0];
    assign wr_stb = bus_sel & bus_wr;
    assign rd_stb = bus_sel & ~bus_wr;

    generate
        for (genvar g = 0; g < NSLOT; g++) begin : g_bind
            // flatten slot bindings for the priority logic
            assign slot_en[g]            = sl_ctl_q[g][SW];
            assign slot_src[g*SW +: SW]  = sl_ctl_q[g][SW-1:0];
        end
    endgenerate

    vic_src #(.NSRC(NSRC)) u_src (
        .hw_lines (src_i),
        .soft_bits(soft_q),
        .en_bits  (en_q),
        .fiq_bits (fsel_q),
        .raw      (raw),
        .irq_stat (irq_stat),
        .fiq_stat (fiq_stat),
        .fiq_req  (fiq_o)
    );

    vic_prio #(.NSRC(NSRC), .NSLOT(NSLOT), .SW(SW), .PW(PW)) u_prio (
        .slot_en  (slot_en),
        .slot_src (slot_src),
        .raw      (raw),
        .irq_stat (irq_stat),
        .cur      (cur),
        .irq_req  (irq_req),
        .win_found(win_found),
        .win_lvl  (win_lvl)
    );

    assign vec_enter = rd_stb & (widx == WI_VECT) & win_found;
    assign vec_leave = wr_stb & (widx == WI_VECT);

    vic_nest #(.NLVL(NLVL), .PW(PW)) u_nest (
        .clk      (clk),
        .rst_n    (rst_n),
        .enter    (vec_enter),
        .enter_lvl(win_lvl),
        .leave    (vec_leave),
        .cur      (cur)
    );

    assign irq_o = irq_req;

    // register writes: set/clear pairs, selects, addresses, slot controls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            soft_q <= '0;
            fsel_q <= '0;
            prot_q <= 1'b0;
            def_q  <= '0;
            for (int i = 0; i < NSLOT; i++) begin
                sl_addr_q[i] <= '0;
                sl_ctl_q[i]  <= '0;
            end
        end else if (wr_stb) begin
            case (widx)
                WI_FSEL:   fsel_q <= bus_wdata[NSRC-1:0];
                WI_EN_SET: en_q   <= en_q | bus_wdata[NSRC-1:0];
                WI_EN_CLR: en_q   <= en_q & ~bus_wdata[NSRC-1:0];
                WI_SW_SET: soft_q <= soft_q | bus_wdata[NSRC-1:0];
                WI_SW_CLR: soft_q <= soft_q & ~bus_wdata[NSRC-1:0];
                WI_PROT:   prot_q <= bus_wdata[0];
                WI_DEF:    def_q  <= bus_wdata;
                default: ;
            endcase
            if (sa_hit) sl_addr_q[sa_idx] <= bus_wdata;
            if (sc_hit) sl_ctl_q[sc_idx]  <= bus_wdata[SW:0];
        end
    end

    // vector read value: winning slot address, or default address
    always_comb begin
        vect_rd = def_q;
        if (win_found && (win_lvl < PW'(NSLOT))) vect_rd = sl_addr_q[win_lvl[SIW-1:0]];
    end

    assign id_shift = ID_BYTES >> {id_off[2:0], 3'b000};

    // read mux: zero for anything unmapped
    always_comb begin
        bus_rdata = '0;
        case (widx)
            WI_IRQ_STAT: bus_rdata = DW'(irq_stat);
            WI_FIQ_STAT: bus_rdata = DW'(fiq_stat);
            WI_RAW:      bus_rdata = DW'(raw);
            WI_FSEL:     bus_rdata = DW'(fsel_q);
            WI_EN_SET:   bus_rdata = DW'(en_q);
            WI_SW_SET:   bus_rdata = DW'(soft_q);
            WI_PROT:     bus_rdata = DW'(prot_q);
            WI_VECT:     bus_rdata = vect_rd;
            WI_DEF:      bus_rdata = def_q;
            default: ;
        endcase
        if (sa_hit) bus_rdata = sl_addr_q[sa_idx];
        if (sc_hit) bus_rdata = DW'(sl_ctl_q[sc_idx]);
        if (id_hit) bus_rdata = DW'(id_shift[7:0]);
    end

    // R7
    no_win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && (widx == WI_VECT) && !win_found) |=> $stable(cur));

    // R2
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (widx == WI_EN_SET)) |=>
        ((en_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

    // R10
    stat_wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (widx == WI_IRQ_STAT)) |=>
        ($stable(en_q) && $stable(soft_q) && $stable(fsel_q) && $stable(cur)));

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur == PW'(NLVL)) && (irq_stat == '0)) |-> !irq_o);
endmodule

// File: tb/vic_ctrl_bench.sv
`timescale 1ns/1ps
module vic_ctrl_bench;
    localparam logic [1:0] K_W = 2'd0;   // bus write
    localparam logic [1:0] K_R = 2'd1;   // bus read, rdata compared
    localparam logic [1:0] K_L = 2'd2;   // drive hardware lines

    typedef struct packed {
        logic [1:0]  kind;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic        eirq;
        logic        efiq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 60;
    localparam vec_t TAB [NV] = '{
        '{K_W, 12'h034, 32'hD000_0000, 32'h0, 1'b0, 1'b0, 4'd6},  // R6 default addr
        '{K_W, 12'h100, 32'hA000_0000, 32'h0, 1'b0, 1'b0, 4'd5},  // R5 slot addrs
        '{K_W, 12'h104, 32'hA100_0000, 32'h0, 1'b0, 1'b0, 4'd5},
        '{K_W, 12'h108, 32'hA200_0000, 32'h0, 1'b0, 1'b0, 4'd5},
        '{K_W, 12'h200, 32'h0000_0025, 32'h0, 1'b0, 1'b0, 4'd5},  // slot0 <- src5
        '{K_W, 12'h204, 32'h0000_0029, 32'h0, 1'b0, 1'b0, 4'd5},  // slot1 <- src9
        '{K_W, 12'h208, 32'h0000_002C, 32'h0, 1'b0, 1'b0, 4'd5},  // slot2 <- src12
        '{K_W, 12'h010, 32'h0010_1220, 32'h0, 1'b0, 1'b0, 4'd2},  // R2 enable set
        '{K_R, 12'h010, 32'h0, 32'h0010_1220, 1'b0, 1'b0, 4'd2},
        '{K_R, 12'h204, 32'h0, 32'h0000_0029, 1'b0, 1'b0, 4'd5},
        '{K_L, 12'h000, 32'h0000_1000, 32'h0, 1'b1, 1'b0, 4'd4},  // R4 idle irq
        '{K_R, 12'h008, 32'h0, 32'h0000_1000, 1'b1, 1'b0, 4'd1},  // R1 raw
        '{K_R, 12'h000, 32'h0, 32'h0000_1000, 1'b1, 1'b0, 4'd1},  // R1 irq status
        '{K_R, 12'h030, 32'h0, 32'hA200_0000, 1'b0, 1'b0, 4'd6},  // R6 enter slot2
        '{K_L, 12'h000, 32'h0000_1200, 32'h0, 1'b1, 1'b0, 4'd9},  // R9 slot1 preempts
        '{K_R, 12'h030, 32'h0, 32'hA100_0000, 1'b0, 1'b0, 4'd6},  // enter slot1
        '{K_L, 12'h000, 32'h0010_1200, 32'h0, 1'b0, 1'b0, 4'd9},  // R9 unvectored blocked
        '{K_L, 12'h000, 32'h0010_1220, 32'h0, 1'b1, 1'b0, 4'd9},  // slot0 preempts
        '{K_R, 12'h030, 32'h0, 32'hA000_0000, 1'b0, 1'b0, 4'd6},  // enter slot0
        '{K_W, 12'h030, 32'h0, 32'h0, 1'b1, 1'b0, 4'd8},          // R8 back to slot1
        '{K_L, 12'h000, 32'h0010_1200, 32'h0, 1'b0, 1'b0, 4'd9},
        '{K_W, 12'h030, 32'h1234_5678, 32'h0, 1'b1, 1'b0, 4'd8},  // R8 back to slot2
        '{K_L, 12'h000, 32'h0010_0000, 32'h0, 1'b0, 1'b0, 4'd9},
        '{K_W, 12'h030, 32'h0, 32'h0, 1'b1, 1'b0, 4'd8},          // R8 back to idle
        '{K_R, 12'h030, 32'h0, 32'hD000_0000, 1'b0, 1'b0, 4'd6},  // R6 unvectored level
        '{K_L, 12'h000, 32'h0010_0200, 32'h0, 1'b1, 1'b0, 4'd9},  // R9 vectored preempts
        '{K_R, 12'h030, 32'h0, 32'hA100_0000, 1'b0, 1'b0, 4'd6},
        '{K_W, 12'h030, 32'h0, 32'h0, 1'b1, 1'b0, 4'd8},          // R8 back to unvectored
        '{K_W, 12'h030, 32'h0, 32'h0, 1'b1, 1'b0, 4'd8},          // R8 back to idle
        '{K_L, 12'h000, 32'h0, 32'h0, 1'b0, 1'b0, 4'd4},
        '{K_R, 12'h030, 32'h0, 32'hD000_0000, 1'b0, 1'b0, 4'd7},  // R7 nothing pending
        '{K_W, 12'h018, 32'h0000_0200, 32'h0, 1'b1, 1'b0, 4'd2},  // R2 soft set
        '{K_R, 12'h018, 32'h0, 32'h0000_0200, 1'b1, 1'b0, 4'd2},
        '{K_W, 12'h01C, 32'h0000_0200, 32'h0, 1'b0, 1'b0, 4'd2},  // R2 soft clear
        '{K_R, 12'h018, 32'h0, 32'h0, 1'b0, 1'b0, 4'd2},
        '{K_W, 12'h00C, 32'h0000_0200, 32'h0, 1'b0, 1'b0, 4'd3},  // R3 fast select
        '{K_W, 12'h018, 32'h0000_0200, 32'h0, 1'b0, 1'b1, 4'd3},
        '{K_R, 12'h004, 32'h0, 32'h0000_0200, 1'b0, 1'b1, 4'd1},  // R1 fast status
        '{K_R, 12'h000, 32'h0, 32'h0, 1'b0, 1'b1, 4'd3},          // R3 excluded
        '{K_W, 12'h014, 32'h0000_0200, 32'h0, 1'b0, 1'b1, 4'd3},  // R3 enable-free
        '{K_R, 12'h010, 32'h0, 32'h0010_1020, 1'b0, 1'b1, 4'd2},  // R2 enable clear
        '{K_W, 12'h000, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b1, 4'd10}, // R10 status write
        '{K_R, 12'h010, 32'h0, 32'h0010_1020, 1'b0, 1'b1, 4'd10},
        '{K_R, 12'h00C, 32'h0, 32'h0000_0200, 1'b0, 1'b1, 4'd10},
        '{K_W, 12'h040, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b1, 4'd10}, // R10 unmapped
        '{K_R, 12'h040, 32'h0, 32'h0, 1'b0, 1'b1, 4'd10},
        '{K_W, 12'h01C, 32'h0000_0200, 32'h0, 1'b0, 1'b0, 4'd3},
        '{K_W, 12'h020, 32'h0000_0003, 32'h0, 1'b0, 1'b0, 4'd11}, // R11 protection
        '{K_R, 12'h020, 32'h0, 32'h0000_0001, 1'b0, 1'b0, 4'd11},
        '{K_R, 12'hFE0, 32'h0, 32'h0000_0052, 1'b0, 1'b0, 4'd11}, // R11 ident
        '{K_R, 12'hFFC, 32'h0, 32'h0000_00B1, 1'b0, 1'b0, 4'd11},
        '{K_W, 12'h208, 32'h0000_000C, 32'h0, 1'b0, 1'b0, 4'd5},  // R5 slot2 off
        '{K_L, 12'h000, 32'h0000_1000, 32'h0, 1'b1, 1'b0, 4'd5},
        '{K_R, 12'h030, 32'h0, 32'hD000_0000, 1'b0, 1'b0, 4'd5},
        '{K_W, 12'h030, 32'h0, 32'h0, 1'b1, 1'b0, 4'd8},
        '{K_L, 12'h000, 32'h0, 32'h0, 1'b0, 1'b0, 4'd4},
        '{K_L, 12'h000, 32'h0000_1020, 32'h0, 1'b1, 1'b0, 4'd5},  // R5 order
        '{K_R, 12'h030, 32'h0, 32'hA000_0000, 1'b0, 1'b0, 4'd5},
        '{K_W, 12'h030, 32'h0, 32'h0, 1'b1, 1'b0, 4'd8},
        '{K_L, 12'h000, 32'h0, 32'h0, 1'b0, 1'b0, 4'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;
    int          n_chk = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;

    vic_ctrl u_vic_ctrl (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic apply(input vec_t v);
        logic [31:0] rd;
        logic        ok;
        @(negedge clk);
        if (v.kind == K_L) begin
            src_i = v.data;
        end else begin
            bus_sel = 1'b1; bus_wr = (v.kind == K_W);
            bus_addr = v.addr; bus_wdata = v.data;
        end
        #2 rd = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        #2;
        ok = (irq_o == v.eirq) && (fiq_o == v.efiq);
        if (v.kind == K_R) ok = ok && (rd == v.exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d addr=%h rdata=%h/%h irq=%b/%b fiq=%b/%b (actual/expected)",
                     v.req, v.addr, rd, v.exp, irq_o, v.eirq, fiq_o, v.efiq);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R12 state after reset
        apply('{K_R, 12'h010, 32'h0, 32'h0, 1'b0, 1'b0, 4'd12});
        apply('{K_R, 12'h030, 32'h0, 32'h0, 1'b0, 1'b0, 4'd12});
        for (int i = 0; i < NV; i++) apply(TAB[i]);
        // R12 reset in the middle of operation clears programmed state
        apply('{K_W, 12'h018, 32'h0000_0020, 32'h0, 1'b1, 1'b0, 4'd12});
        do_reset();
        apply('{K_R, 12'h010, 32'h0, 32'h0, 1'b0, 1'b0, 4'd12});
        apply('{K_R, 12'h018, 32'h0, 32'h0, 1'b0, 1'b0, 4'd12});
        apply('{K_R, 12'h100, 32'h0, 32'h0, 1'b0, 1'b0, 4'd12});
        apply('{K_R, 12'h204, 32'h0, 32'h0, 1'b0, 1'b0, 4'd12});
        apply('{K_R, 12'h034, 32'h0, 32'h0, 1'b0, 1'b0, 4'd12});
        // R8 exit write while idle changes nothing; R12 idle after reset
        apply('{K_W, 12'h010, 32'h0010_0000, 32'h0, 1'b0, 1'b0, 4'd12});
        apply('{K_L, 12'h000, 32'h0010_0000, 32'h0, 1'b1, 1'b0, 4'd12});
        apply('{K_W, 12'h030, 32'h0, 32'h0, 1'b1, 1'b0, 4'd8});
        apply('{K_W, 12'h030, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0, 4'd8});
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule